// File: doc/BRIEF.md
# General-Purpose Pin Bank Controller

The block controls a bank of general-purpose pins, one set of pad control lines per pin. Software configures each pin through a small register write port. A per-pin input-mode bit picks analog or digital operation. A per-pin output-mode bit picks push-pull or open-drain driving. A port latch holds the output values. A configuration word holds a pull-up disable bit that acts on the whole bank, and a route bit that hands the output value of every pin to a peripheral signal in place of the latch.

From these settings the block drives four lines to each pad: high-side drive enable, low-side drive enable, weak pull-up enable and digital receiver enable. It samples the real pad level through a synchronizer and returns it as the readback value. An analog pin always reads back zero. The electrical pad and any analog path are outside the block. The bench models the pad as a wired resolution of the drivers and an external source.

Top module: `gpio_bank`

## Requirements
- R1: Reset values: input-mode register all ones (digital), output-mode register all zeros (open-drain), latch all ones, pull-up disable and route both 0. The pins then enable neither driver, and enable the pull-up and the receiver.
- R2: On a write with `wrEn` high, address 0 loads input-mode, 1 loads output-mode, 2 loads the latch, and 3 loads configuration (bit 0 pull-up disable, bit 1 route). `rdData` returns these registers at the same addresses, with configuration zero-extended. Address 4 returns the synchronized readback, and any other address returns 0. At most one register loads per write.
- R3: A pin whose input-mode bit is 0 (analog) has both drivers, its pull-up and its receiver disabled, and its readback is 0.
- R4: A digital pin whose output-mode bit is 1 (push-pull) enables the high driver for output value 1 and the low driver for output value 0.
- R5: A digital pin whose output-mode bit is 0 (open-drain) never enables the high driver. It enables the low driver for output value 0 and neither driver for output value 1.
- R6: On a digital pin the weak pull-up is enabled exactly when the low driver is off and pull-up disable is 0.
- R7: With pull-up disable set to 1, no pin enables its pull-up.
- R8: The readback of a digital pin is the pad level, not the output value, delayed by two clock edges. A pin that is analog in the current cycle reads 0.
- R9: With route set to 1, the output value of each pin is `periphOut` in place of the latch.
- R10: No pin ever enables its high and low drivers together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write register address |
| wrData | input | NUM_PINS | Write data |
| rdAddr | input | 3 | Read register address |
| rdData | output | NUM_PINS | Read data for `rdAddr` |
| periphOut | input | NUM_PINS | Peripheral output values used when route is set |
| padLevel | input | NUM_PINS | Actual level seen on each pad |
| padDriveHi | output | NUM_PINS | High-side driver enable per pin |
| padDriveLo | output | NUM_PINS | Low-side driver enable per pin |
| padPullUp | output | NUM_PINS | Weak pull-up enable per pin |
| padRxEn | output | NUM_PINS | Digital receiver enable per pin |
| rdIn | output | NUM_PINS | Synchronized input readback per pin |

## Verification
The hardest case to reach is a pin whose readback disagrees with its own output value. An open-drain pin has released its pad for a logic 1, and an external source pulls that pad low. The bench resolves every pad from the block's own driver enables plus a random external level, so released pins take random values while driven pins follow their drivers. A long random phase then mixes mode changes, route toggles and pull-up disable writes with that contention, and checks the two-cycle readback delay and the analog zero against a behavioural model on every cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE_IN  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE_OUT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LATCH    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CFG      = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_INPUT    = 3'd4;

  typedef enum logic [2:0] {
    RD_MODE_IN,
    RD_MODE_OUT,
    RD_LATCH,
    RD_CFG,
    RD_INPUT,
    RD_NONE
  } rdSel_e;

  typedef struct packed {
    logic   ldModeIn;
    logic   ldModeOut;
    logic   ldLatch;
    logic   ldCfg;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe.ldModeIn  = wrEn && (wrAddr == ADDR_MODE_IN);
    strobe.ldModeOut = wrEn && (wrAddr == ADDR_MODE_OUT);
    strobe.ldLatch   = wrEn && (wrAddr == ADDR_LATCH);
    strobe.ldCfg     = wrEn && (wrAddr == ADDR_CFG);
    unique case (rdAddr)
      ADDR_MODE_IN:  strobe.rdSel = RD_MODE_IN;
      ADDR_MODE_OUT: strobe.rdSel = RD_MODE_OUT;
      ADDR_LATCH:    strobe.rdSel = RD_LATCH;
      ADDR_CFG:      strobe.rdSel = RD_CFG;
      ADDR_INPUT:    strobe.rdSel = RD_INPUT;
      default:       strobe.rdSel = RD_NONE;
    endcase
  end

  // R2: a write loads one register at most, and only when wrEn is high
  assert_single_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ldModeIn, strobe.ldModeOut, strobe.ldLatch, strobe.ldCfg}));
  assert_no_load_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strobe.ldModeIn || strobe.ldModeOut || strobe.ldLatch || strobe.ldCfg));

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] periphOut,
  input  logic [NUM_PINS-1:0] padLevel,
  output logic [NUM_PINS-1:0] padDriveHi,
  output logic [NUM_PINS-1:0] padDriveLo,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] padRxEn,
  output logic [NUM_PINS-1:0] rdIn,
  output logic [NUM_PINS-1:0] rdData
);

  localparam int CFG_W = 2;
  localparam int CFG_PAD = NUM_PINS - CFG_W;

  logic [NUM_PINS-1:0] modeInQ;
  logic [NUM_PINS-1:0] modeOutQ;
  logic [NUM_PINS-1:0] latchQ;
  logic                pullOffQ;
  logic                routeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeInQ  <= '1;
      modeOutQ <= '0;
      latchQ   <= '1;
      pullOffQ <= 1'b0;
      routeQ   <= 1'b0;
    end else begin
      if (strobe.ldModeIn)  modeInQ  <= wrData;
      if (strobe.ldModeOut) modeOutQ <= wrData;
      if (strobe.ldLatch)   latchQ   <= wrData;
      if (strobe.ldCfg) begin
        pullOffQ <= wrData[0];
        routeQ   <= wrData[1];
      end
    end
  end

  logic [NUM_PINS-1:0] outVal;
  assign outVal = routeQ ? periphOut : latchQ;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic isDigital;
    logic sinkLow;
    assign isDigital     = modeInQ[p];
    assign sinkLow       = isDigital & ~outVal[p];
    assign padDriveLo[p] = sinkLow;
    assign padDriveHi[p] = isDigital & modeOutQ[p] & outVal[p];
    assign padPullUp[p]  = isDigital & ~pullOffQ & ~sinkLow;
    assign padRxEn[p]    = isDigital;
  end

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[s] <= '0;
      end else if (s == 0) begin
        syncQ[s] <= padLevel & padRxEn;
      end else begin
        syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign rdIn = syncQ[SYNC_STAGES-1] & modeInQ;

  always_comb begin
    unique case (strobe.rdSel)
      RD_MODE_IN:  rdData = modeInQ;
      RD_MODE_OUT: rdData = modeOutQ;
      RD_LATCH:    rdData = latchQ;
      RD_CFG:      rdData = {{CFG_PAD{1'b0}}, routeQ, pullOffQ};
      RD_INPUT:    rdData = rdIn;
      default:     rdData = '0;
    endcase
  end

  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rstN)
    (padDriveHi & padDriveLo) == '0);
  assert_analog_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((padDriveHi | padDriveLo | padPullUp | padRxEn | rdIn) & ~modeInQ) == '0);
  assert_od_no_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (padDriveHi & ~modeOutQ) == '0);
  assert_pull_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padDriveLo) == '0);
  assert_pull_global_R7: assert property (@(posedge clk) disable iff (!rstN)
    pullOffQ |-> (padPullUp == '0));

  if (SYNC_STAGES == 2) begin : g_sync_chk
    assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
      (upCnt == 2'd3) |->
        (rdIn == ($past(padLevel, 2) & $past(padRxEn, 2) & modeInQ)));
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [2:0]          rdAddr,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] periphOut,
  input  logic [NUM_PINS-1:0] padLevel,
  output logic [NUM_PINS-1:0] padDriveHi,
  output logic [NUM_PINS-1:0] padDriveLo,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] padRxEn,
  output logic [NUM_PINS-1:0] rdIn
);

  regStrobe_t strobe;

  gpio_bank_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .strobe (strobe)
  );

  gpio_bank_datapath #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .periphOut  (periphOut),
    .padLevel   (padLevel),
    .padDriveHi (padDriveHi),
    .padDriveLo (padDriveLo),
    .padPullUp  (padPullUp),
    .padRxEn    (padRxEn),
    .rdIn       (rdIn),
    .rdData     (rdData)
  );

endmodule

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   wrAddr = '0;
  logic [N-1:0] wrData = '0;
  logic [2:0]   rdAddr = '0;
  logic [N-1:0] rdData;
  logic [N-1:0] periphOut = '0;
  logic [N-1:0] extLevel = '1;
  logic [N-1:0] padLevel;
  logic [N-1:0] padDriveHi, padDriveLo, padPullUp, padRxEn, rdIn;

  always #2 clk = ~clk;

  // pad resolution: drivers win, otherwise external source decides
  assign padLevel = padDriveHi | (~padDriveLo & extLevel);

  gpio_bank #(.NUM_PINS(N)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .periphOut(periphOut), .padLevel(padLevel),
    .padDriveHi(padDriveHi), .padDriveLo(padDriveLo), .padPullUp(padPullUp),
    .padRxEn(padRxEn), .rdIn(rdIn)
  );

  // behavioural reference state
  logic [N-1:0] mIn, mOut, mLat, s1, s2;
  logic         mPullOff, mRoute;
  int compared = 0;
  int mismatched = 0;
  bit running = 0;
  bit done = 0;

  function automatic logic [N-1:0] expOut();
    return mRoute ? periphOut : mLat;
  endfunction
  function automatic logic [N-1:0] expHi();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = mIn[i] && mOut[i] && expOut() >> i & 1'b1;
    return r;
  endfunction
  function automatic logic [N-1:0] expLo();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = mIn[i] && !expOut()[i];
    return r;
  endfunction
  function automatic logic [N-1:0] expPull();
    logic [N-1:0] r;
    logic [N-1:0] lo;
    lo = expLo();
    for (int i = 0; i < N; i++) r[i] = mIn[i] && !lo[i] && !mPullOff;
    return r;
  endfunction
  function automatic logic [N-1:0] expRd();
    case (rdAddr)
      3'd0: return mIn;
      3'd1: return mOut;
      3'd2: return mLat;
      3'd3: return {{(N-2){1'b0}}, mRoute, mPullOff};
      3'd4: return s2 & mIn;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIn = '1; mOut = '0; mLat = '1; mPullOff = 0; mRoute = 0; s1 = '0; s2 = '0;
    end else begin
      logic [N-1:0] pad;
      pad = expHi() | (~expLo() & extLevel);
      s2 = s1;
      s1 = pad & mIn;
      if (wrEn) begin
        case (wrAddr)
          3'd0: mIn = wrData;
          3'd1: mOut = wrData;
          3'd2: mLat = wrData;
          3'd3: begin mPullOff = wrData[0]; mRoute = wrData[1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      // R4 R5 R9: driver enables from mode, latch or peripheral
      chk("R4/R5/R9", "padDriveHi", padDriveHi, expHi());
      chk("R4/R5/R9", "padDriveLo", padDriveLo, expLo());
      // R6 R7: pull-up release and global disable; R3 analog quiet
      chk("R6/R7/R3", "padPullUp", padPullUp, expPull());
      chk("R3", "padRxEn", padRxEn, mIn);
      // R8: synchronized pad readback, zero for analog pins
      chk("R8", "rdIn", rdIn, s2 & mIn);
      chk("R2", "rdData", rdData, expRd());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d; rdAddr = 3'($urandom_range(0, 7));
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n, input bit rnd);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      rdAddr = 3'($urandom_range(0, 7));
      if (rnd) begin
        extLevel = N'($urandom);
        periphOut = N'($urandom);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    running = 1;
    // R1: reset state, read each register once
    for (int a = 0; a < 5; a++) begin
      rdAddr = 3'(a);
      @(negedge clk);
      #1;
    end
    // R4: push-pull toggling
    wr(3'd1, '1);
    wr(3'd2, 8'hA5); idle(4, 0);
    wr(3'd2, 8'h5A); idle(4, 0);
    // R5: open-drain, released pins pulled low externally (readback != latch)
    wr(3'd1, 8'h0F);
    wr(3'd2, '1);
    extLevel = 8'h33; idle(6, 0);
    rdAddr = 3'd4; idle(1, 0);
    // R3: analog pins
    wr(3'd0, 8'hC3); idle(6, 1);
    // R7: global pull-up disable
    wr(3'd3, 8'h01); idle(6, 1);
    wr(3'd3, 8'h00);
    // R9: route to peripheral
    wr(3'd3, 8'h02); idle(10, 1);
    wr(3'd3, 8'h00);
    wr(3'd0, '1);
    // R2: unused addresses load nothing
    wr(3'd5, 8'h00); wr(3'd7, 8'h00); idle(3, 0);
    // random mix, R10 covered throughout
    for (int k = 0; k < 1500; k++) begin
      @(posedge clk); #1;
      wrEn = ($urandom_range(0, 3) == 0);
      wrAddr = 3'($urandom_range(0, 5));
      wrData = N'($urandom);
      rdAddr = 3'($urandom_range(0, 7));
      extLevel = N'($urandom);
      periphOut = N'($urandom);
    end
    @(posedge clk); #1 wrEn = 1'b0;
    idle(4, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired");
      end
    join_any
    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule